// File: doc/BRIEF.md
# Hot-Swap Two-Wire Segment Join Controller

This block decides when the two-wire serial bus on a plug-in card may be tied to the live bus on the backplane, and it repeats line activity between the two segments once they are tied. It sees the line levels of both segments, a supply-good flag for each side and an enable input. It drives open-drain pull-down requests into each segment. It also raises flags that switch on the analog precharge and the rise-time boost circuits.

After power and enable are present, the block waits for the backplane transfer in progress to end. The end is marked either by a stop condition (data rising while clock is high) or by both backplane lines staying high for a programmable idle time. At that moment both card lines must also read high. Only then are the segments joined.

While joined, each line acts as one wired-AND net across both sides. A per-line origin tracker stops the repeater from holding itself low. Dropping enable, or losing either supply, separates the segments on the next clock edge.

Top module: `busjoin_ctrl`

## Requirements
- R1: After reset, state_o reads 0, joined, precharge_en and accel_en are low and all four pull-down outputs are low.
- R2: While either supply-good flag is low, state_o is 0 (no power) and the segments stay separated whatever the bus lines do.
- R3: precharge_en is high exactly while both supplies are good, enable is high and the segments are not joined. With enable low it is low, and state_o reads 1 (disabled).
- R4: While qualifying (state_o = 2), a backplane stop condition (data rising while clock is high, seen on the synchronised levels) joins the segments if both card lines are high. state_o then reads 3.
- R5: While qualifying, both backplane lines staying high for IDLE_CYC consecutive cycles joins the segments if both card lines are high. The join does not happen noticeably earlier than that.
- R6: A stop or idle event that occurs while either card line is low does not join. The block keeps waiting for a later event.
- R7: When joined, an external low on a backplane line asserts the pull-down on the same card line, and the pull-down is released after the backplane low goes away.
- R8: When joined, an external low on a card line asserts the pull-down on the same backplane line. If the card side still holds the line low when the backplane releases it, the card becomes the new origin (clock stretching).
- R9: The block never pulls both sides of one line low at once. Once all external lows are gone, both lines return high and stay high.
- R10: accel_en is high only while joined.
- R11: Driving enable low separates the segments on the next clock edge. After enable returns, a new stop or idle event is required before joining again.
- R12: If a supply-good flag drops while joined, the segments separate on the next clock edge.
- R13: state_o encodes 0 = no power, 1 = disabled, 2 = qualifying, 3 = joined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low forces separation |
| pwr_bp_ok | input | 1 | Backplane supply good |
| pwr_cd_ok | input | 1 | Card supply good |
| bp_sda_i | input | 1 | Backplane data line level |
| bp_scl_i | input | 1 | Backplane clock line level |
| cd_sda_i | input | 1 | Card data line level |
| cd_scl_i | input | 1 | Card clock line level |
| bp_sda_pd | output | 1 | Pull backplane data low |
| bp_scl_pd | output | 1 | Pull backplane clock low |
| cd_sda_pd | output | 1 | Pull card data low |
| cd_scl_pd | output | 1 | Pull card clock low |
| joined | output | 1 | Segments are joined |
| precharge_en | output | 1 | Precharge circuit enable |
| accel_en | output | 1 | Rise-time boost enable |
| state_o | output | 2 | Sequencer state code |

## Verification
The bench presents a stop while a card line is held low. A design that ignored the card-high check would join into a busy card. The bench then holds a card line low through a full idle window, and checks that no join happens either on the idle event or after it.

When joined, the bench releases one side's low and watches both lines. A repeater that mistook its own pull-down for an external low would latch the bus low forever. The bench also runs a clock-stretch handover, where a design that dropped the handover would release a clock that the card still holds.

The bench drops enable and a supply while joined and checks that separation happens within one cycle. After enable returns, it checks that the block does not rejoin early and requalifies only on a fresh idle window.

// File: rtl/busjoin_pkg.sv
package busjoin_pkg;

  // Sequencer state codes, visible on state_o.
  typedef enum logic [1:0] {
    SQ_NOPWR   = 2'd0,
    SQ_OFF     = 2'd1,
    SQ_QUALIFY = 2'd2,
    SQ_JOINED  = 2'd3
  } seq_state_t;

  // Per-line origin tracker states.
  typedef enum logic [2:0] {
    RL_IDLE   = 3'd0,
    RL_FROM_A = 3'd1,  // backplane side pulled first
    RL_FROM_B = 3'd2,  // card side pulled first
    RL_HOLD_A = 3'd3,  // our backplane pull-down just released
    RL_HOLD_B = 3'd4   // our card pull-down just released
  } relay_state_t;

endpackage

// File: rtl/busjoin_sync.sv
module busjoin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '1;
          else        chain_q[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/busjoin_bpmon.sv
module busjoin_bpmon #(
  parameter int IDLE_CYC = 4750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic watch_en,
  input  logic sda_s,
  input  logic scl_s,
  output logic stop_p,
  output logic idle_p
);

  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] CNT_END  = CW'(IDLE_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_CYC - 1);

  logic          sda_q, scl_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          both_high;

  assign both_high = sda_s & scl_s;

  always_comb begin
    cnt_d = cnt_q;
    if (!watch_en || !both_high) cnt_d = '0;
    else if (cnt_q != CNT_END)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      sda_q <= sda_s;
      scl_q <= scl_s;
      cnt_q <= cnt_d;
    end
  end

  // Data rises while clock stayed high across the edge.
  assign stop_p = watch_en & sda_s & ~sda_q & scl_s & scl_q;
  // One pulse when the high stretch reaches the idle length.
  assign idle_p = watch_en & both_high & (cnt_q == CNT_LAST);

endmodule

// File: rtl/busjoin_relay.sv
module busjoin_relay
  import busjoin_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic a_lo,
  input  logic b_lo,
  output logic a_pd,
  output logic b_pd
);

  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SET_LAST = SW'(SETTLE - 1);

  relay_state_t  st_q, st_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          hold_done;

  assign hold_done = (cnt_q == SET_LAST);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RL_IDLE: begin
        if (a_lo)      st_d = RL_FROM_A;
        else if (b_lo) st_d = RL_FROM_B;
      end
      RL_FROM_A: if (!a_lo) st_d = RL_HOLD_B;
      RL_FROM_B: if (!b_lo) st_d = RL_HOLD_A;
      RL_HOLD_B: begin
        // lows on the card side are our own echo until settled
        if (a_lo)           st_d = RL_FROM_A;
        else if (hold_done) st_d = RL_IDLE;
      end
      RL_HOLD_A: begin
        if (b_lo)           st_d = RL_FROM_B;
        else if (hold_done) st_d = RL_IDLE;
      end
      default: st_d = RL_IDLE;
    endcase
    if (!active) st_d = RL_IDLE;
  end

  always_comb begin
    cnt_d = '0;
    if ((st_q == RL_HOLD_A || st_q == RL_HOLD_B) && (st_d == st_q))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RL_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign a_pd = active & (st_q == RL_FROM_B);
  assign b_pd = active & (st_q == RL_FROM_A);

endmodule

// File: rtl/busjoin_seq.sv
module busjoin_seq
  import busjoin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       en_i,
  input  logic       event_p,
  input  logic       card_high,
  output seq_state_t st_o
);

  seq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_NOPWR:   st_d = en_i ? SQ_QUALIFY : SQ_OFF;
      SQ_OFF:     if (en_i) st_d = SQ_QUALIFY;
      SQ_QUALIFY: begin
        if (!en_i)                     st_d = SQ_OFF;
        else if (event_p && card_high) st_d = SQ_JOINED;
      end
      SQ_JOINED:  if (!en_i) st_d = SQ_OFF;
      default:    st_d = SQ_NOPWR;
    endcase
    if (!pwr_ok) st_d = SQ_NOPWR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_NOPWR;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

endmodule

// File: rtl/busjoin_ctrl.sv
module busjoin_ctrl
  import busjoin_pkg::*;
#(
  parameter int IDLE_CYC    = 4750,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       pwr_bp_ok,
  input  logic       pwr_cd_ok,
  input  logic       bp_sda_i,
  input  logic       bp_scl_i,
  input  logic       cd_sda_i,
  input  logic       cd_scl_i,
  output logic       bp_sda_pd,
  output logic       bp_scl_pd,
  output logic       cd_sda_pd,
  output logic       cd_scl_pd,
  output logic       joined,
  output logic       precharge_en,
  output logic       accel_en,
  output logic [1:0] state_o
);

  localparam int NLINES = 2;               // index 0 data, 1 clock
  localparam int SETTLE = SYNC_STAGES + 1;

  logic [NLINES-1:0] bp_s, cd_s, bp_pd, cd_pd;
  logic              stop_p, idle_p, watch_en, active;
  seq_state_t        st;

  busjoin_sync #(.WIDTH(2*NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cd_scl_i, cd_sda_i, bp_scl_i, bp_sda_i}),
    .q_o   ({cd_s, bp_s})
  );

  assign watch_en = (st == SQ_QUALIFY);
  assign active   = (st == SQ_JOINED);

  busjoin_bpmon #(.IDLE_CYC(IDLE_CYC)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .watch_en (watch_en),
    .sda_s    (bp_s[0]),
    .scl_s    (bp_s[1]),
    .stop_p   (stop_p),
    .idle_p   (idle_p)
  );

  busjoin_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_bp_ok & pwr_cd_ok),
    .en_i      (en_i),
    .event_p   (stop_p | idle_p),
    .card_high (&cd_s),
    .st_o      (st)
  );

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      busjoin_relay #(.SETTLE(SETTLE)) u_relay (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .a_lo   (~bp_s[i]),
        .b_lo   (~cd_s[i]),
        .a_pd   (bp_pd[i]),
        .b_pd   (cd_pd[i])
      );
    end
  endgenerate

  assign bp_sda_pd    = bp_pd[0];
  assign bp_scl_pd    = bp_pd[1];
  assign cd_sda_pd    = cd_pd[0];
  assign cd_scl_pd    = cd_pd[1];
  assign joined       = active;
  assign precharge_en = watch_en;
  assign accel_en     = active;
  assign state_o      = st;

endmodule

// File: rtl/busjoin_ctrl_chk.sv
module busjoin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       pwr_bp_ok,
  input logic       pwr_cd_ok,
  input logic       bp_sda_pd,
  input logic       bp_scl_pd,
  input logic       cd_sda_pd,
  input logic       cd_scl_pd,
  input logic       joined,
  input logic       precharge_en,
  input logic [1:0] state_o
);

  assert_unpowered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_bp_ok && pwr_cd_ok) |=> (state_o == 2'd0));

  assert_precharge_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge_en && joined));

  assert_join_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(joined) |-> ($past(state_o) == 2'd2));

  assert_one_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_sda_pd && cd_sda_pd) && !(bp_scl_pd && cd_scl_pd));

  assert_en_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !joined);

  assert_pwr_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && !(pwr_bp_ok && pwr_cd_ok)) |=> !joined);

endmodule

bind busjoin_ctrl busjoin_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .pwr_bp_ok    (pwr_bp_ok),
  .pwr_cd_ok    (pwr_cd_ok),
  .bp_sda_pd    (bp_sda_pd),
  .bp_scl_pd    (bp_scl_pd),
  .cd_sda_pd    (cd_sda_pd),
  .cd_scl_pd    (cd_scl_pd),
  .joined       (joined),
  .precharge_en (precharge_en),
  .state_o      (state_o)
);

// File: tb/busjoin_ctrl_test.sv
`timescale 1ns/1ps
module busjoin_ctrl_test;

  localparam int IDLE_CYC = 4750;

  logic clk = 1'b0;
  logic rst_n;
  logic en_i, pwr_bp_ok, pwr_cd_ok;
  logic ext_bp_sda, ext_bp_scl, ext_cd_sda, ext_cd_scl;  // 1 = external device pulls low
  logic bp_sda, bp_scl, cd_sda, cd_scl;
  logic bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd;
  logic joined, precharge_en, accel_en;
  logic [1:0] state_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  // wired-AND bus model
  assign bp_sda = ~(ext_bp_sda | bp_sda_pd);
  assign bp_scl = ~(ext_bp_scl | bp_scl_pd);
  assign cd_sda = ~(ext_cd_sda | cd_sda_pd);
  assign cd_scl = ~(ext_cd_scl | cd_scl_pd);

  busjoin_ctrl #(.IDLE_CYC(IDLE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .pwr_bp_ok(pwr_bp_ok), .pwr_cd_ok(pwr_cd_ok),
    .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .cd_sda_i(cd_sda), .cd_scl_i(cd_scl),
    .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd),
    .cd_sda_pd(cd_sda_pd), .cd_scl_pd(cd_scl_pd),
    .joined(joined), .precharge_en(precharge_en), .accel_en(accel_en),
    .state_o(state_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bp_stop();
    ext_bp_sda = 1'b1; cyc(5);
    ext_bp_sda = 1'b0; cyc(6);
  endtask

  task automatic t_reset();
    check("R1 state", state_o, 0);
    check("R1 joined", joined, 0);
    check("R1 precharge", precharge_en, 0);
    check("R1 accel", accel_en, 0);
    check("R1 pulldowns", {bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd}, 0);
  endtask

  task automatic t_unpowered();
    en_i = 1'b1; pwr_bp_ok = 1'b1; pwr_cd_ok = 1'b0;
    bp_stop(); cyc(IDLE_CYC / 4);
    check("R2 state no power", state_o, 0);
    check("R2 no join", joined, 0);
    check("R2 no precharge", precharge_en, 0);
  endtask

  task automatic t_disabled_then_enable();
    en_i = 1'b0; pwr_cd_ok = 1'b1; cyc(3);
    check("R13 disabled code", state_o, 1);
    check("R3 precharge off when disabled", precharge_en, 0);
    en_i = 1'b1; cyc(2);
    check("R13 qualify code", state_o, 2);
    check("R3 precharge on while qualifying", precharge_en, 1);
    check("R10 accel off before join", accel_en, 0);
  endtask

  task automatic t_stop_join();
    ext_cd_scl = 1'b1; cyc(4);
    bp_stop();
    check("R6 stop with card low no join", state_o, 2);
    ext_cd_scl = 1'b0; cyc(6);
    check("R6 still waiting", joined, 0);
    bp_stop();
    check("R4 stop joins", joined, 1);
    check("R13 joined code", state_o, 3);
    check("R10 accel on", accel_en, 1);
    check("R3 precharge off joined", precharge_en, 0);
  endtask

  task automatic t_relay();
    ext_bp_sda = 1'b1; cyc(6);
    check("R7 card data pulled", cd_sda_pd, 1);
    check("R7 card data low", cd_sda, 0);
    ext_bp_sda = 1'b0; cyc(10);
    check("R7 card data released", cd_sda_pd, 0);
    check("R9 both data high", {bp_sda, cd_sda}, 3);
    cyc(20);
    check("R9 data stays high", {bp_sda, cd_sda}, 3);
    ext_cd_scl = 1'b1; cyc(6);
    check("R8 backplane clock pulled", bp_scl_pd, 1);
    ext_cd_scl = 1'b0; cyc(10);
    check("R8 backplane clock released", {bp_scl_pd, bp_scl, cd_scl}, 3);
    // clock stretch handover
    ext_bp_scl = 1'b1; cyc(6);
    ext_cd_scl = 1'b1; cyc(3);
    ext_bp_scl = 1'b0; cyc(12);
    check("R8 stretch hands over", bp_scl_pd, 1);
    check("R8 backplane clock held low", bp_scl, 0);
    ext_cd_scl = 1'b0; cyc(12);
    check("R9 all pulldowns clear", {bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd}, 0);
    check("R9 clock high both sides", {bp_scl, cd_scl}, 3);
  endtask

  task automatic t_enable_drop();
    en_i = 1'b0; cyc(1);
    check("R11 disconnect next cycle", joined, 0);
    check("R10 accel off", accel_en, 0);
    check("R11 disabled state", state_o, 1);
    en_i = 1'b1; cyc(20);
    check("R11 no immediate rejoin", state_o, 2);
    cyc(IDLE_CYC - 40);
    check("R5 no join before idle time", joined, 0);
    cyc(40);
    check("R5 idle joins", joined, 1);
  endtask

  task automatic t_power_drop();
    pwr_bp_ok = 1'b0; cyc(1);
    check("R12 disconnect on supply loss", joined, 0);
    check("R12 state no power", state_o, 0);
    pwr_bp_ok = 1'b1; ext_cd_sda = 1'b1; cyc(IDLE_CYC + 30);
    check("R6 idle with card low no join", state_o, 2);
    ext_cd_sda = 1'b0; cyc(30);
    check("R6 no late join", joined, 0);
    bp_stop();
    check("R4 later stop joins", joined, 1);
  endtask

  initial begin
    rst_n = 1'b0; en_i = 1'b0; pwr_bp_ok = 1'b0; pwr_cd_ok = 1'b0;
    ext_bp_sda = 1'b0; ext_bp_scl = 1'b0; ext_cd_sda = 1'b0; ext_cd_scl = 1'b0;
    cyc(4);
    t_reset();
    rst_n = 1'b1; cyc(2);
    t_unpowered();
    t_disabled_then_enable();
    t_stop_join();
    t_relay();
    t_enable_drop();
    t_power_drop();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule